// File: doc/BRIEF.md
# Receive Control-Character Recognizer

This block sits between a UART receiver's character output and the receive FIFO. Every received character is compared against three programmable characters: a resume (Xon) character, a pause (Xoff) character and a station address character. Flow-control matches drive a transmit-pause output. Address matches drive a wake/doze gate that decides whether data characters reach the FIFO. Each of the three recognized characters can be removed from the data stream on its own, and a removed character still takes its full effect.

A host programs the block through a small write-only register port. The character registers can be written one at a time. Two bulk commands also exist: one restores the default Xon/Xoff pair, and one copies a single host byte into all three character registers. Recognition events set sticky status bits that the host clears by writing ones. The interrupt output is the OR of the enabled status bits. Every output is registered, so a character presented in one cycle shows its effect one cycle later.

Top module: `rx_ctrl_char_filter`

## Requirements
- R1: After reset, fifo_push, tx_pause, status and irq are 0 and rx_enable is 1. The resume character is 0x11 and the pause character is 0x13, so with flow control on, 0x13 sets tx_pause and 0x11 clears it.
- R2: A character that is not stripped and not gated off produces fifo_push=1 with fifo_data equal to rx_data in the cycle after rx_valid. fifo_push is 0 in every cycle not preceded by a valid character.
- R3: With control bit 0 (flow enable) set, a received pause character sets tx_pause and a received resume character clears it. If both registers hold the same value, pause wins. With bit 0 clear, tx_pause does not change. In wake mode, characters flagged as addresses take no part in flow matching.
- R4: Host address 0 writes the resume character, 1 the pause character and 2 the address character. Address 6 loads 0x11/0x13 into resume/pause and leaves the address character unchanged. Address 7 writes host_wdata into all three. Matching uses the register contents from the cycle after the write.
- R5: A character received with rx_break=1 never counts as a match of any kind. It leaves tx_pause, the wake state and the status bits unchanged.
- R6: With control bit 1 (wake mode) set, rx_enable is 1 only while the receiver is awake. It goes to 1 the cycle after an address-flagged character equal to the address register arrives. While asleep, only such a matching address character can be pushed.
- R7: With wake mode and control bit 2 (auto-doze) set, an address-flagged character that differs from the address register clears rx_enable and is not pushed. Without auto-doze, such a character leaves the wake state alone and is pushed if the receiver is awake.
- R8: Control bits 3, 4 and 5 strip matched resume, pause and address characters respectively. A stripped character is not pushed but still updates tx_pause, the wake state and the status bits.
- R9: status bit 0 records a resume match, bit 1 a pause match, bit 2 an address match and bit 3 an address mismatch. The bits hold until the host writes ones to them at address 5. A match in the same cycle as the clear wins.
- R10: irq is 1 exactly when some status bit is 1 and its enable bit, written at address 4, is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| rx_valid | input | 1 | A received character is present |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Character arrived with a break condition |
| rx_is_addr | input | 1 | Character is flagged as an address (ninth bit) |
| fifo_push | output | 1 | Write strobe toward the receive FIFO |
| fifo_data | output | 8 | Character toward the receive FIFO |
| tx_pause | output | 1 | Transmitter pause request |
| rx_enable | output | 1 | Receiver gate state (wake/doze) |
| status | output | 4 | Sticky recognition events |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted wake state shows on rx_enable one cycle after the next character. It also shows in fifo_push on the first data character, which is either dropped or passed wrongly. A wrong pause state or compare register shows on tx_pause one cycle after the first character equal to the resume or pause value. A wrong strip or status decision shows at fifo_push and status in that same cycle. The bench sweeps all 256 character codes, with and without the address flag, under all 64 control settings. Each step is compared with a model of the requirements.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int AW     = 3;
  localparam int NCHAR  = 3;
  localparam int NSTAT  = 4;
  localparam int CTRL_W = 6;
  // character register slots (host address equals slot index)
  localparam int IDX_XON  = 0;
  localparam int IDX_XOFF = 1;
  localparam int IDX_ADR  = 2;
  // host addresses
  localparam logic [AW-1:0] A_CTRL = 3'd3;
  localparam logic [AW-1:0] A_IEN  = 3'd4;
  localparam logic [AW-1:0] A_CLR  = 3'd5;
  localparam logic [AW-1:0] A_LOAD = 3'd6;
  localparam logic [AW-1:0] A_GANG = 3'd7;
  // control bits
  localparam int C_FLOW  = 0;
  localparam int C_WAKE  = 1;
  localparam int C_DOZE  = 2;
  localparam int C_SXON  = 3;
  localparam int C_SXOFF = 4;
  localparam int C_SADR  = 5;
  // status bits
  localparam int S_XON   = 0;
  localparam int S_XOFF  = 1;
  localparam int S_AHIT  = 2;
  localparam int S_AMISS = 3;
endpackage

// File: rtl/ccr_regs.sv
module ccr_regs
  import ccr_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] XON_DEF  = 8'h11,
  parameter logic [DW-1:0] XOFF_DEF = 8'h13,
  parameter logic [DW-1:0] ADR_DEF  = 8'h00
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [NCHAR-1:0][DW-1:0]   chars,
  output logic [CTRL_W-1:0]          ctrl,
  output logic [NSTAT-1:0]           inten
);
  function automatic logic [DW-1:0] def_of(input int idx);
    case (idx)
      IDX_XON:  def_of = XON_DEF;
      IDX_XOFF: def_of = XOFF_DEF;
      default:  def_of = ADR_DEF;
    endcase
  endfunction

  for (genvar g = 0; g < NCHAR; g++) begin : g_char
    logic [DW-1:0] ch_q, ch_d;
    logic          ch_en;
    always_comb begin
      ch_en = 1'b0;
      ch_d  = ch_q;
      if (wr) begin
        if (addr == AW'(g) || addr == A_GANG) begin
          ch_en = 1'b1;
          ch_d  = wdata;
        end else if (addr == A_LOAD && g != IDX_ADR) begin
          ch_en = 1'b1;
          ch_d  = def_of(g);
        end
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ch_q <= def_of(g);
      else if (ch_en) ch_q <= ch_d;
    end
    assign chars[g] = ch_q;
  end

  logic ctrl_en, ien_en;
  assign ctrl_en = wr && addr == A_CTRL;
  assign ien_en  = wr && addr == A_IEN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      inten <= '0;
    end else begin
      if (ctrl_en) ctrl  <= wdata[CTRL_W-1:0];
      if (ien_en)  inten <= wdata[NSTAT-1:0];
    end
  end
endmodule

// File: rtl/ccr_match.sv
module ccr_match
  import ccr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]            data,
  input  logic [NCHAR-1:0][DW-1:0] chars,
  output logic [NCHAR-1:0]         eq
);
  for (genvar g = 0; g < NCHAR; g++) begin : g_cmp
    assign eq[g] = (data == chars[g]);
  end
endmodule

// File: rtl/ccr_core.sv
module ccr_core
  import ccr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_break,
  input  logic              rx_is_addr,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [NCHAR-1:0]  eq,
  input  logic              clr_wr,
  input  logic [NSTAT-1:0]  clr_mask,
  output logic              fifo_push,
  output logic [DW-1:0]     fifo_data,
  output logic              tx_pause,
  output logic              awake,
  output logic [NSTAT-1:0]  status
);
  logic flow, wake, doze, clean;
  logic hit_xon, hit_xoff, hit_adr, miss_adr, pass, strip;
  logic push_d, pause_d, awake_d;
  logic [NSTAT-1:0] ev, status_d;

  assign flow  = ctrl[C_FLOW];
  assign wake  = ctrl[C_WAKE];
  assign doze  = ctrl[C_DOZE];
  assign clean = rx_valid && !rx_break;

  always_comb begin
    hit_xon  = clean && flow && !(wake && rx_is_addr) && eq[IDX_XON];
    hit_xoff = clean && flow && !(wake && rx_is_addr) && eq[IDX_XOFF];
    hit_adr  = clean && wake && rx_is_addr && eq[IDX_ADR];
    miss_adr = clean && wake && rx_is_addr && !eq[IDX_ADR];
    pass     = !wake || hit_adr || (awake && !(miss_adr && doze));
    strip    = (hit_xon && ctrl[C_SXON]) || (hit_xoff && ctrl[C_SXOFF]) ||
               (hit_adr && ctrl[C_SADR]);
    push_d   = rx_valid && pass && !strip;

    pause_d = tx_pause;
    if (hit_xoff)     pause_d = 1'b1;
    else if (hit_xon) pause_d = 1'b0;

    awake_d = awake;
    if (hit_adr)               awake_d = 1'b1;
    else if (miss_adr && doze) awake_d = 1'b0;

    ev = '0;
    ev[S_XON]   = hit_xon;
    ev[S_XOFF]  = hit_xoff;
    ev[S_AHIT]  = hit_adr;
    ev[S_AMISS] = miss_adr;
    status_d = (status & ~(clr_wr ? clr_mask : '0)) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_push <= 1'b0;
      fifo_data <= '0;
      tx_pause  <= 1'b0;
      awake     <= 1'b0;
      status    <= '0;
    end else begin
      fifo_push <= push_d;
      if (rx_valid) fifo_data <= rx_data;
      tx_pause  <= pause_d;
      awake     <= awake_d;
      status    <= status_d;
    end
  end
endmodule

// File: rtl/rx_ctrl_char_filter.sv
module rx_ctrl_char_filter
  import ccr_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] XON_DEF  = 8'h11,
  parameter logic [DW-1:0] XOFF_DEF = 8'h13,
  parameter logic [DW-1:0] ADR_DEF  = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_break,
  input  logic             rx_is_addr,
  output logic             fifo_push,
  output logic [DW-1:0]    fifo_data,
  output logic             tx_pause,
  output logic             rx_enable,
  output logic [NSTAT-1:0] status,
  output logic             irq
);
  logic [NCHAR-1:0][DW-1:0] chars;
  logic [CTRL_W-1:0]        ctrl_q;
  logic [NSTAT-1:0]         inten_q;
  logic [NCHAR-1:0]         eq;
  logic                     awake_q;
  logic                     clr_wr;

  assign clr_wr = host_wr && host_addr == A_CLR;

  ccr_regs #(.DW(DW), .XON_DEF(XON_DEF), .XOFF_DEF(XOFF_DEF), .ADR_DEF(ADR_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .chars(chars), .ctrl(ctrl_q), .inten(inten_q)
  );

  ccr_match #(.DW(DW)) u_match (.data(rx_data), .chars(chars), .eq(eq));

  ccr_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rx_is_addr(rx_is_addr), .ctrl(ctrl_q), .eq(eq),
    .clr_wr(clr_wr), .clr_mask(host_wdata[NSTAT-1:0]),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .tx_pause(tx_pause),
    .awake(awake_q), .status(status)
  );

  assign rx_enable = !ctrl_q[C_WAKE] || awake_q;
  assign irq       = |(status & inten_q);
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
#(
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic [AW-1:0]    host_addr,
  input logic             rx_valid,
  input logic [DW-1:0]    rx_data,
  input logic             rx_break,
  input logic             rx_is_addr,
  input logic             fifo_push,
  input logic [DW-1:0]    fifo_data,
  input logic             tx_pause,
  input logic             rx_enable,
  input logic [NSTAT-1:0] status,
  input logic             wake_en,
  input logic             doze_en,
  input logic [DW-1:0]    adr_char
);
  AST_PUSH_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> $past(rx_valid)); // R2
  AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> fifo_data == $past(rx_data)); // R2
  AST_PAUSE_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pause != $past(tx_pause)) |-> $past(rx_valid && !rx_break)); // R3
  AST_BREAK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_break && !host_wr) |=> ($stable(status) && $stable(tx_pause))); // R5
  AST_ASLEEP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_is_addr && wake_en && !rx_enable) |=> !fifo_push); // R6
  AST_DOZE_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_is_addr && !rx_break && wake_en && doze_en &&
     rx_data != adr_char && !host_wr) |=> (!rx_enable && !fifo_push)); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(status) & ~status)) |-> $past(host_wr && host_addr == A_CLR)); // R9
endmodule

bind rx_ctrl_char_filter ccr_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
  .rx_is_addr(rx_is_addr), .fifo_push(fifo_push), .fifo_data(fifo_data),
  .tx_pause(tx_pause), .rx_enable(rx_enable), .status(status),
  .wake_en(ctrl_q[ccr_pkg::C_WAKE]), .doze_en(ctrl_q[ccr_pkg::C_DOZE]),
  .adr_char(chars[ccr_pkg::IDX_ADR])
);

// File: tb/test_rx_ctrl_char_filter.sv
`timescale 1ns/1ps
module test_rx_ctrl_char_filter;
  logic       clk, rst_n;
  logic       host_wr;
  logic [2:0] host_addr;
  logic [7:0] host_wdata;
  logic       rx_valid, rx_break, rx_is_addr;
  logic [7:0] rx_data;
  logic       fifo_push, tx_pause, rx_enable, irq;
  logic [7:0] fifo_data;
  logic [3:0] status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [7:0] xon_m, xoff_m, adr_m;
  logic [5:0] ctrl_m;
  logic [3:0] ie_m, st_m;
  logic       pause_m, awake_m;

  rx_ctrl_char_filter i_rx_ctrl_char_filter (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rx_is_addr(rx_is_addr), .fifo_push(fifo_push),
    .fifo_data(fifo_data), .tx_pause(tx_pause), .rx_enable(rx_enable),
    .status(status), .irq(irq)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit do_rx, input logic [7:0] d, input bit a, input bit b,
                      input bit do_wr, input logic [2:0] wa, input logic [7:0] wd,
                      input string tag);
    logic mx, mf, ma, mm, pass, strip, epush, flow, wake, doze;
    logic [3:0] ev;
    flow  = ctrl_m[0]; wake = ctrl_m[1]; doze = ctrl_m[2];
    mx    = do_rx && !b && flow && !(wake && a) && d == xon_m;
    mf    = do_rx && !b && flow && !(wake && a) && d == xoff_m;
    ma    = do_rx && !b && wake && a && d == adr_m;
    mm    = do_rx && !b && wake && a && d != adr_m;
    pass  = !wake || ma || (awake_m && !(mm && doze));
    strip = (mx && ctrl_m[3]) || (mf && ctrl_m[4]) || (ma && ctrl_m[5]);
    epush = do_rx && pass && !strip;
    ev    = {mm, ma, mf, mx};
    @(negedge clk);
    rx_valid = do_rx; rx_data = d; rx_is_addr = a; rx_break = b;
    host_wr = do_wr; host_addr = wa; host_wdata = wd;
    // model update
    if (mf) pause_m = 1'b1; else if (mx) pause_m = 1'b0;
    if (ma) awake_m = 1'b1; else if (mm && doze) awake_m = 1'b0;
    st_m = (st_m & ~((do_wr && wa == 3'd5) ? wd[3:0] : 4'h0)) | ev;
    if (do_wr) begin
      case (wa)
        3'd0: xon_m = wd;
        3'd1: xoff_m = wd;
        3'd2: adr_m = wd;
        3'd3: ctrl_m = wd[5:0];
        3'd4: ie_m = wd[3:0];
        3'd6: begin xon_m = 8'h11; xoff_m = 8'h13; end
        3'd7: begin xon_m = wd; xoff_m = wd; adr_m = wd; end
        default: ;
      endcase
    end
    @(negedge clk);
    rx_valid = 0; host_wr = 0; rx_break = 0;
    chk(tag, fifo_push, epush);
    if (epush) chk({tag, " data"}, fifo_data, d);
    chk("R3 tx_pause", tx_pause, pause_m);
    chk("R6 rx_enable", rx_enable, !ctrl_m[1] || awake_m);
    chk("R9 status", status, st_m);
    chk("R10 irq", irq, |(st_m & ie_m));
  endtask

  task automatic hw(input logic [2:0] wa, input logic [7:0] wd, input string tag);
    step(0, 8'h00, 0, 0, 1, wa, wd, tag);
  endtask

  task automatic rx(input logic [7:0] d, input bit a, input bit b, input string tag);
    step(1, d, a, b, 0, 3'd0, 8'h00, tag);
  endtask

  initial begin
    rst_n = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    rx_valid = 0; rx_data = 0; rx_break = 0; rx_is_addr = 0;
    xon_m = 8'h11; xoff_m = 8'h13; adr_m = 8'h00; ctrl_m = '0; ie_m = '0; st_m = '0;
    pause_m = 0; awake_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 push", fifo_push, 0);
    chk("R1 pause", tx_pause, 0);
    chk("R1 rx_enable", rx_enable, 1);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);

    // R1 default flow characters
    hw(3'd3, 8'h01, "R1 cfg");
    rx(8'h13, 0, 0, "R1 default xoff");
    chk("R1 pause after 0x13", tx_pause, 1);
    rx(8'h11, 0, 0, "R1 default xon");
    chk("R1 pause after 0x11", tx_pause, 0);
    rx(8'h41, 0, 0, "R2 plain char");

    // R4 individual write, gang write, default load
    hw(3'd0, 8'h41, "R4 wr xon");
    hw(3'd1, 8'h42, "R4 wr xoff");
    rx(8'h13, 0, 0, "R4 old xoff ignored");
    chk("R4 pause", tx_pause, 0);
    rx(8'h42, 0, 0, "R4 new xoff");
    chk("R4 pause new", tx_pause, 1);
    hw(3'd7, 8'h77, "R4 gang");
    rx(8'h41, 0, 0, "R4 old xon ignored");
    chk("R4 pause held", tx_pause, 1);
    hw(3'd5, 8'h0F, "R9 clear");
    rx(8'h77, 0, 0, "R4 gang char both");
    chk("R4 status both", status, 4'h3);
    hw(3'd6, 8'h00, "R4 load");
    rx(8'h11, 0, 0, "R4 loaded xon");
    chk("R4 pause cleared", tx_pause, 0);

    // R5 break never matches
    hw(3'd5, 8'h0F, "R9 clear");
    rx(8'h13, 0, 1, "R5 break xoff");
    chk("R5 pause", tx_pause, 0);
    chk("R5 status", status, 0);

    // R9 set wins over simultaneous clear
    hw(3'd4, 8'h01, "R10 ien");
    step(1, 8'h11, 0, 0, 1, 3'd5, 8'h0F, "R9 set wins");
    chk("R9 set wins bit", status, 4'h1);
    chk("R10 irq enabled", irq, 1);

    // R6, R7, R8 directed
    hw(3'd2, 8'h5A, "R4 adr");
    hw(3'd3, 8'h26, "R7 cfg");          // wake, doze, strip adr
    rx(8'h33, 0, 0, "R6 asleep drop");
    rx(8'h5A, 1, 0, "R8 stripped wake");
    chk("R6 awake", rx_enable, 1);
    rx(8'h34, 0, 0, "R6 awake data");
    rx(8'h5B, 1, 0, "R7 doze miss");
    chk("R7 dozed", rx_enable, 0);

    // sweep every control setting, every code, both flag values
    for (int cfg = 0; cfg < 64; cfg++) begin
      hw(3'd3, 8'(cfg), "R2 cfg");
      hw(3'd4, 8'(4'hF ^ cfg[3:0]), "R10 ien");
      hw(3'd6, 8'h00, "R4 load");
      hw(3'd2, 8'h5A, "R4 adr");
      hw(3'd5, 8'h0F, "R9 clear");
      for (int d = 0; d < 256; d++) begin
        for (int a = 0; a < 2; a++) begin
          rx(8'(d), a[0], (d[2:0] == 3'b111) || (d == 8'h13 && a == 1),
             "R2,R3,R5,R6,R7,R8 sweep");
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule